// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the clocked control unit for a multi-cycle 32-bit RISC datapath in which one ALU and one memory serve both instructions and data. It reads the opcode and function fields from the instruction register and the ALU zero flag. From these it drives every enable and multiplexer select in the datapath, so that each instruction completes in three, four or five cycles. The fetch of the next instruction begins in the cycle right after the previous one ends.

The sequencer has ten states. Fetch and decode are common to all instructions. After them the path splits into a jump state, a branch state, an ALU compute state followed by an ALU write-back state, an address-compute state, a store state, and a load that is split into a read cycle and a write-back cycle. Decode captures a small instruction class register. The later states use it to pick between the register and immediate ALU operands, the destination register, the branch polarity and the jump target source. Every output is decoded from the registered state except the conditional PC write, which also depends on the zero flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `pc_wr`, `pc_wr_cond`, `mem_rd`, `mem_wr`, `ir_wr` and `reg_wr` are all 0. The first cycle after `rst` falls is a fetch cycle, even if reset arrived in the middle of an instruction.
- R2: A fetch cycle drives `ir_wr`=1, `mem_rd`=1, `addr_src`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_class`=0 (add), `pc_src`=0 (ALU result) and `pc_wr`=1. The next cycle is decode: it has no write enables, with `alu_a_sel`=0, `alu_b_sel`=3 (offset shifted by 2) and `alu_class`=0.
- R3: The opcode encodings are: 0x00 register format, 0x02 jump, 0x03 jump-and-link, 0x04 branch-equal, 0x05 branch-not-equal, 0x23 load and 0x2B store. Immediate ALU operations use 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0F, 0x10 and 0x11. Inside the register format, function 0x08 is jump-register.
- R4: A register-format ALU instruction lasts four cycles. Cycle 3 has `alu_a_sel`=1, `alu_b_sel`=0 (B) and `alu_class`=2 (by function field). Cycle 4 has `reg_wr`=1, `dst_sel`=1 (rd) and `wb_sel`=0 (ALUOut).
- R5: An immediate ALU instruction lasts four cycles. Cycle 3 has `alu_b_sel`=2 (sign-extended immediate) and `alu_class`=3 (by opcode). Cycle 4 has `reg_wr`=1, `dst_sel`=0 (rt) and `wb_sel`=0.
- R6: A load lasts five cycles. Cycle 3 has `alu_b_sel`=2 and `alu_class`=0. Cycle 4 has `mem_rd`=1 with `addr_src`=1 (ALUOut). Cycle 5 has `reg_wr`=1, `dst_sel`=0 and `wb_sel`=1 (memory data register).
- R7: A store lasts four cycles. Cycle 3 computes the address as for a load. Cycle 4 has `mem_wr`=1 with `addr_src`=1, and the store never asserts `reg_wr`.
- R8: A branch lasts three cycles. Cycle 3 has `alu_b_sel`=0, `alu_class`=1 (subtract), `pc_src`=1 (ALUOut) and `pc_wr`=0. In that cycle `pc_wr_cond` equals `zero` for branch-equal and the inverse of `zero` for branch-not-equal.
- R9: A jump lasts three cycles. Cycle 3 has `pc_wr`=1 with `pc_src`=2 (jump target). For jump-and-link, cycle 3 also has `reg_wr`=1 with `dst_sel`=2 (register 31) and `wb_sel`=2 (incremented PC).
- R10: Jump-register lasts three cycles. Cycle 3 has `pc_wr`=1 with `pc_src`=3 (register A) and no `reg_wr`.
- R11: An opcode not listed in R3 lasts two cycles. After fetch it asserts no `reg_wr`, `mem_wr`, `pc_wr` or `pc_wr_cond`.
- R12: `pc_wr` is asserted once per instruction in fetch, and a second time only in the completion cycle of a jump. `pc_wr_cond` is asserted nowhere but in the branch cycle.
- R13: `mem_rd` and `mem_wr` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | Branch PC write, already qualified by the flag and the polarity |
| addr_src | output | 1 | Memory address source: 0 PC, 1 ALUOut |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 2 | Destination: 0 rt, 1 rd, 2 register 31 |
| wb_sel | output | 2 | Write data: 0 ALUOut, 1 memory data register, 2 PC |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 0 B, 1 four, 2 immediate, 3 immediate shifted by 2 |
| alu_class | output | 2 | ALU class: 0 add, 1 subtract, 2 by function, 3 by opcode |
| pc_src | output | 2 | Next PC: 0 ALU result, 1 ALUOut, 2 jump target, 3 register A |

## Verification
Two functions can fall in the same cycle. The jump-and-link completion cycle writes the PC and also writes the link register from the PC that fetch has already incremented. That cycle is reached by sweeping every opcode, and the bench requires `pc_wr`, `reg_wr`, `dst_sel`=2 and `wb_sel`=2 to appear together in the third cycle, with exactly two PC writes across the instruction. The second case is the branch cycle, where the zero flag meets the branch polarity. Each branch opcode runs with both flag values, and the bench counts conditional PC writes against the rule of R8. A reset asserted while an ALU write-back is due must suppress that write.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    parameter int OPC_W = 6;
    parameter int FN_W  = 6;
    parameter int SEL_W = 2;

    typedef enum logic [3:0] {
        S_FETCH  = 4'd0,
        S_DECODE = 4'd1,
        S_JUMP   = 4'd2,
        S_BRANCH = 4'd3,
        S_ALU_EX = 4'd4,
        S_ALU_WB = 4'd5,
        S_MEM_AD = 4'd6,
        S_MEM_ST = 4'd7,
        S_MEM_RD = 4'd8,
        S_MEM_WB = 4'd9
    } state_e;

    typedef enum logic [2:0] {
        C_BAD    = 3'd0,
        C_RALU   = 3'd1,
        C_IALU   = 3'd2,
        C_LOAD   = 3'd3,
        C_STORE  = 3'd4,
        C_BRANCH = 3'd5,
        C_JUMP   = 3'd6
    } cls_e;

    // opcode values
    localparam logic [OPC_W-1:0] OP_REG  = 6'h00;
    localparam logic [OPC_W-1:0] OP_J    = 6'h02;
    localparam logic [OPC_W-1:0] OP_JAL  = 6'h03;
    localparam logic [OPC_W-1:0] OP_BEQ  = 6'h04;
    localparam logic [OPC_W-1:0] OP_BNE  = 6'h05;
    localparam logic [OPC_W-1:0] OP_ADDI = 6'h08;
    localparam logic [OPC_W-1:0] OP_SUBI = 6'h09;
    localparam logic [OPC_W-1:0] OP_SLTI = 6'h0A;
    localparam logic [OPC_W-1:0] OP_SGTI = 6'h0B;
    localparam logic [OPC_W-1:0] OP_ANDI = 6'h0C;
    localparam logic [OPC_W-1:0] OP_ORI  = 6'h0D;
    localparam logic [OPC_W-1:0] OP_LUI  = 6'h0F;
    localparam logic [OPC_W-1:0] OP_SHL  = 6'h10;
    localparam logic [OPC_W-1:0] OP_SHR  = 6'h11;
    localparam logic [OPC_W-1:0] OP_LW   = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW   = 6'h2B;
    localparam logic [FN_W-1:0]  FN_JR   = 6'h08;

    // select encodings
    localparam logic [SEL_W-1:0] DST_RT   = 2'd0;
    localparam logic [SEL_W-1:0] DST_RD   = 2'd1;
    localparam logic [SEL_W-1:0] DST_LINK = 2'd2;
    localparam logic [SEL_W-1:0] WB_ALU   = 2'd0;
    localparam logic [SEL_W-1:0] WB_MDR   = 2'd1;
    localparam logic [SEL_W-1:0] WB_PC    = 2'd2;
    localparam logic [SEL_W-1:0] BS_REG   = 2'd0;
    localparam logic [SEL_W-1:0] BS_FOUR  = 2'd1;
    localparam logic [SEL_W-1:0] BS_IMM   = 2'd2;
    localparam logic [SEL_W-1:0] BS_OFS   = 2'd3;
    localparam logic [SEL_W-1:0] AC_ADD   = 2'd0;
    localparam logic [SEL_W-1:0] AC_SUB   = 2'd1;
    localparam logic [SEL_W-1:0] AC_FUNCT = 2'd2;
    localparam logic [SEL_W-1:0] AC_OPC   = 2'd3;
    localparam logic [SEL_W-1:0] PS_ALU   = 2'd0;
    localparam logic [SEL_W-1:0] PS_OUT   = 2'd1;
    localparam logic [SEL_W-1:0] PS_JT    = 2'd2;
    localparam logic [SEL_W-1:0] PS_REG   = 2'd3;

    typedef struct packed {
        cls_e cls;
        logic br_ne;    // branch taken on inequality
        logic link;     // jump writes register 31
        logic via_reg;  // jump target from register A
    } dec_t;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             addr_src;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_wr;
        logic             reg_wr;
        logic [SEL_W-1:0] dst_sel;
        logic [SEL_W-1:0] wb_sel;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_class;
        logic [SEL_W-1:0] pc_src;
    } ctl_t;

endpackage

// File: rtl/mc_opdec.sv
module mc_opdec
    import mc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    output dec_t             dec_o
);
    always_comb begin
        dec_o         = '{cls: C_BAD, br_ne: 1'b0, link: 1'b0, via_reg: 1'b0};
        unique case (opcode_i)
            OP_REG: begin
                if (funct_i == FN_JR) begin
                    dec_o.cls     = C_JUMP;
                    dec_o.via_reg = 1'b1;
                end else begin
                    dec_o.cls     = C_RALU;
                end
            end
            OP_J:    dec_o.cls = C_JUMP;
            OP_JAL: begin
                dec_o.cls  = C_JUMP;
                dec_o.link = 1'b1;
            end
            OP_BEQ:  dec_o.cls = C_BRANCH;
            OP_BNE: begin
                dec_o.cls   = C_BRANCH;
                dec_o.br_ne = 1'b1;
            end
            OP_ADDI, OP_SUBI, OP_SLTI, OP_SGTI, OP_ANDI, OP_ORI,
            OP_LUI, OP_SHL, OP_SHR:
                dec_o.cls = C_IALU;
            OP_LW:   dec_o.cls = C_LOAD;
            OP_SW:   dec_o.cls = C_STORE;
            default: dec_o.cls = C_BAD;
        endcase
    end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
    import mc_ctrl_pkg::*;
(
    input  state_e state_i,
    input  dec_t   dec_now_i,   // decoded from the instruction register
    input  dec_t   dec_q_i,     // class captured at decode
    output state_e next_o
);
    always_comb begin
        next_o = S_FETCH;
        case (state_i)
            S_FETCH:  next_o = S_DECODE;
            S_DECODE: begin
                case (dec_now_i.cls)
                    C_RALU, C_IALU:   next_o = S_ALU_EX;
                    C_LOAD, C_STORE:  next_o = S_MEM_AD;
                    C_BRANCH:         next_o = S_BRANCH;
                    C_JUMP:           next_o = S_JUMP;
                    default:          next_o = S_FETCH;
                endcase
            end
            S_ALU_EX: next_o = S_ALU_WB;
            S_MEM_AD: next_o = (dec_q_i.cls == C_STORE) ? S_MEM_ST : S_MEM_RD;
            S_MEM_RD: next_o = S_MEM_WB;
            default:  next_o = S_FETCH;   // jump, branch, write-backs, store
        endcase
    end
endmodule

// File: rtl/mc_outdec.sv
module mc_outdec
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e state_i,
    input  dec_t   dec_i,
    input  logic   zero_i,
    output ctl_t   ctl_o
);
    always_comb begin
        ctl_o = '0;
        case (state_i)
            S_FETCH: begin
                ctl_o.ir_wr     = 1'b1;
                ctl_o.mem_rd    = 1'b1;
                ctl_o.addr_src  = 1'b0;
                ctl_o.alu_a_sel = 1'b0;
                ctl_o.alu_b_sel = BS_FOUR;
                ctl_o.alu_class = AC_ADD;
                ctl_o.pc_src    = PS_ALU;
                ctl_o.pc_wr     = 1'b1;
            end
            S_DECODE: begin
                ctl_o.alu_a_sel = 1'b0;
                ctl_o.alu_b_sel = BS_OFS;
                ctl_o.alu_class = AC_ADD;
            end
            S_JUMP: begin
                ctl_o.pc_wr  = 1'b1;
                ctl_o.pc_src = dec_i.via_reg ? PS_REG : PS_JT;
                ctl_o.reg_wr = dec_i.link;
                ctl_o.dst_sel = DST_LINK;
                ctl_o.wb_sel  = WB_PC;
            end
            S_BRANCH: begin
                ctl_o.alu_a_sel  = 1'b1;
                ctl_o.alu_b_sel  = BS_REG;
                ctl_o.alu_class  = AC_SUB;
                ctl_o.pc_src     = PS_OUT;
                ctl_o.pc_wr_cond = zero_i ^ dec_i.br_ne;
            end
            S_ALU_EX: begin
                ctl_o.alu_a_sel = 1'b1;
                ctl_o.alu_b_sel = (dec_i.cls == C_IALU) ? BS_IMM : BS_REG;
                ctl_o.alu_class = (dec_i.cls == C_IALU) ? AC_OPC : AC_FUNCT;
            end
            S_ALU_WB: begin
                ctl_o.reg_wr  = 1'b1;
                ctl_o.dst_sel = (dec_i.cls == C_IALU) ? DST_RT : DST_RD;
                ctl_o.wb_sel  = WB_ALU;
            end
            S_MEM_AD: begin
                ctl_o.alu_a_sel = 1'b1;
                ctl_o.alu_b_sel = BS_IMM;
                ctl_o.alu_class = AC_ADD;
            end
            S_MEM_ST: begin
                ctl_o.addr_src = 1'b1;
                ctl_o.mem_wr   = 1'b1;
            end
            S_MEM_RD: begin
                ctl_o.addr_src = 1'b1;
                ctl_o.mem_rd   = 1'b1;
            end
            S_MEM_WB: begin
                ctl_o.reg_wr  = 1'b1;
                ctl_o.dst_sel = DST_RT;
                ctl_o.wb_sel  = WB_MDR;
            end
            default: ctl_o = '0;
        endcase
    end

    // conditional PC write only in the branch state (R12)
    p_cond_in_branch_r12: assert property (@(posedge clk) disable iff (rst)
        ctl_o.pc_wr_cond |-> (state_i == S_BRANCH));

    // link write shares its cycle with the jump PC write (R9)
    p_link_with_jump_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.reg_wr && ctl_o.dst_sel == DST_LINK) |-> (ctl_o.pc_wr && dec_i.link));

    // a store never writes the register file (R7)
    p_store_no_regwr_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_i.cls == C_STORE && state_i != S_FETCH && state_i != S_DECODE) |-> !ctl_o.reg_wr);
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             zero,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             addr_src,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_wr,
    output logic             reg_wr,
    output logic [SEL_W-1:0] dst_sel,
    output logic [SEL_W-1:0] wb_sel,
    output logic             alu_a_sel,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic [SEL_W-1:0] alu_class,
    output logic [SEL_W-1:0] pc_src
);
    typedef struct packed {
        state_e state;
        dec_t   dec;
    } reg_t;

    reg_t   r_d, r_q;
    dec_t   dec_now;
    state_e nxt_state;
    ctl_t   ctl_raw, ctl;

    mc_opdec u_opdec (
        .opcode_i (opcode),
        .funct_i  (funct),
        .dec_o    (dec_now)
    );

    mc_seq u_seq (
        .state_i   (r_q.state),
        .dec_now_i (dec_now),
        .dec_q_i   (r_q.dec),
        .next_o    (nxt_state)
    );

    mc_outdec u_outdec (
        .clk     (clk),
        .rst     (rst),
        .state_i (r_q.state),
        .dec_i   (r_q.dec),
        .zero_i  (zero),
        .ctl_o   (ctl_raw)
    );

    always_comb begin
        r_d       = r_q;
        r_d.state = nxt_state;
        if (r_q.state == S_DECODE) begin
            r_d.dec = dec_now;
        end
        if (rst) begin
            r_d.state = S_FETCH;
            r_d.dec   = '{cls: C_BAD, br_ne: 1'b0, link: 1'b0, via_reg: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    // all enables held off during reset
    assign ctl = rst ? '0 : ctl_raw;

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign addr_src   = ctl.addr_src;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign ir_wr      = ctl.ir_wr;
    assign reg_wr     = ctl.reg_wr;
    assign dst_sel    = ctl.dst_sel;
    assign wb_sel     = ctl.wb_sel;
    assign alu_a_sel  = ctl.alu_a_sel;
    assign alu_b_sel  = ctl.alu_b_sel;
    assign alu_class  = ctl.alu_class;
    assign pc_src     = ctl.pc_src;

    // reset leaves the sequencer in fetch (R1)
    p_reset_to_fetch_r1: assert property (@(posedge clk)
        rst |=> (r_q.state == S_FETCH));

    // fetch is always followed by decode (R2)
    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_FETCH) |=> (r_q.state == S_DECODE));

    // load read cycle is followed by its write-back (R6)
    p_load_split_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_MEM_RD) |=> (r_q.state == S_MEM_WB));

    // completion states hand over to fetch at once (R12)
    p_finish_to_fetch_r12: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_JUMP || r_q.state == S_BRANCH || r_q.state == S_ALU_WB ||
         r_q.state == S_MEM_ST || r_q.state == S_MEM_WB) |=> (r_q.state == S_FETCH));

    // unknown opcode in decode goes back to fetch (R11)
    p_bad_to_fetch_r11: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == S_DECODE && dec_now.cls == C_BAD) |=> ir_wr);

    // single memory port (R13)
    p_mem_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

// File: tb/mc_ctrl_fsm_test.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero = 1'b0;
    logic       pc_wr, pc_wr_cond, addr_src, mem_rd, mem_wr, ir_wr, reg_wr, alu_a_sel;
    logic [1:0] dst_sel, wb_sel, alu_b_sel, alu_class, pc_src;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    mc_ctrl_fsm uut (
        .clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .zero(zero),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_src(addr_src),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .reg_wr(reg_wr),
        .dst_sel(dst_sel), .wb_sel(wb_sel), .alu_a_sel(alu_a_sel),
        .alu_b_sel(alu_b_sel), .alu_class(alu_class), .pc_src(pc_src)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (op=%h fn=%h z=%0d)",
                     req, what, act, exp, opcode, funct, zero);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    function automatic int wr_bits();
        return int'({pc_wr, pc_wr_cond, mem_rd, mem_wr, ir_wr, reg_wr});
    endfunction

    // expected behaviour from the requirements
    task automatic expect_of(input int op, input int fn, input bit z, output string req,
                             output int len, output int rw, output int dst, output int wb,
                             output int mw, output int mr, output int pcw, output int cnd,
                             output int psrc, output int b3, output int c3);
        req = "R11"; len = 2; rw = 0; dst = -1; wb = -1; mw = 0; mr = 0;
        pcw = 1; cnd = 0; psrc = 0; b3 = -1; c3 = -1;
        if (op == 'h00 && fn == 'h08) begin
            req = "R10"; len = 3; pcw = 2; psrc = 3;
        end else if (op == 'h00) begin
            req = "R4"; len = 4; rw = 1; dst = 1; wb = 0; b3 = 0; c3 = 2;
        end else if (op == 'h02 || op == 'h03) begin
            req = "R9"; len = 3; pcw = 2; psrc = 2;
            if (op == 'h03) begin rw = 1; dst = 2; wb = 2; end
        end else if (op == 'h04 || op == 'h05) begin
            req = "R8"; len = 3; psrc = 1; b3 = 0; c3 = 1;
            cnd = (op == 'h04) ? int'(z) : int'(!z);
        end else if ((op >= 'h08 && op <= 'h0D) || op == 'h0F || op == 'h10 || op == 'h11) begin
            req = "R5"; len = 4; rw = 1; dst = 0; wb = 0; b3 = 2; c3 = 3;
        end else if (op == 'h23) begin
            req = "R6"; len = 5; rw = 1; dst = 0; wb = 1; mr = 1; b3 = 2; c3 = 0;
        end else if (op == 'h2B) begin
            req = "R7"; len = 4; mw = 1; b3 = 2; c3 = 0;
        end
    endtask

    task automatic run_one(input int op, input int fn, input bit z);
        string req;
        int len, rw, dst, wb, mw, mr, pcw, cnd, psrc, b3, c3;
        int n, n_rw, l_dst, l_wb, n_mw, n_mr, n_pcw, n_cnd, l_psrc, s_b3, s_c3, bad_addr, both;
        while (!ir_wr) @(negedge clk);
        opcode = 6'(op); funct = 6'(fn); zero = z;
        expect_of(op, fn, z, req, len, rw, dst, wb, mw, mr, pcw, cnd, psrc, b3, c3);
        // fetch cycle (R2)
        chk("R2", "fetch selects",
            int'({mem_rd, addr_src, alu_a_sel, alu_b_sel, alu_class, pc_src, pc_wr}),
            int'({1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 2'd0, 1'b1}));
        n = 1; n_rw = 0; l_dst = -1; l_wb = -1; n_mw = 0; n_mr = 0; n_pcw = 1; n_cnd = 0;
        l_psrc = 0; s_b3 = -1; s_c3 = -1; bad_addr = 0; both = 0;
        forever begin
            @(negedge clk);
            if (ir_wr || n >= 8) break;
            n++;
            if (n == 2)
                chk("R2", "decode selects",
                    int'({wr_bits(), alu_a_sel, alu_b_sel, alu_class}),
                    int'({6'd0, 1'b0, 2'd3, 2'd0}));
            if (n == 3) begin s_b3 = int'(alu_b_sel); s_c3 = int'(alu_class); end
            if (reg_wr) begin n_rw++; l_dst = int'(dst_sel); l_wb = int'(wb_sel); end
            if (mem_wr) n_mw++;
            if (mem_rd) n_mr++;
            if ((mem_wr || mem_rd) && !addr_src) bad_addr++;
            if (mem_wr && mem_rd) both++;
            if (pc_wr) n_pcw++;
            if (pc_wr_cond) n_cnd++;
            l_psrc = int'(pc_src);
        end
        chk(req, "length", n, len);
        chk(req, "reg writes", n_rw, rw);
        if (rw > 0) begin
            chk(req, "dst_sel", l_dst, dst);
            chk(req, "wb_sel", l_wb, wb);
        end
        chk(req, "mem writes", n_mw, mw);
        chk(req, "mem reads after fetch", n_mr, mr);
        chk(req, "data address from ALUOut", bad_addr, 0);
        chk("R13", "read and write together", both, 0);
        chk("R12", "pc writes", n_pcw, pcw);
        chk("R12", "conditional pc writes", n_cnd, cnd);
        chk(req, "last pc_src", l_psrc, psrc);
        if (b3 >= 0) begin
            chk(req, "cycle3 alu_b_sel", s_b3, b3);
            chk(req, "cycle3 alu_class", s_c3, c3);
        end
    endtask

    initial begin
        int fnl[4] = '{'h20, 'h22, 'h08, 'h2A};
        // reset hold (R1)
        repeat (3) begin
            @(negedge clk);
            chk("R1", "enables in reset", wr_bits(), 0);
        end
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "first cycle is fetch", int'(ir_wr), 1);

        // sweep every opcode, both flag values (R3)
        for (int op = 0; op < 64; op++) begin
            for (int zz = 0; zz < 2; zz++) begin
                if (op == 0) begin
                    for (int k = 0; k < 4; k++) run_one(op, fnl[k], zz[0]);
                end else begin
                    run_one(op, 0, zz[0]);
                end
            end
        end

        // reset while an ALU write-back is due (R1, R13 of reset path)
        while (!ir_wr) @(negedge clk);
        opcode = 6'h00; funct = 6'h20;
        @(negedge clk);             // decode
        @(negedge clk);             // execute
        @(posedge clk); #1 rst = 1'b1;
        @(negedge clk);
        chk("R1", "write-back suppressed by reset", wr_bits(), 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "fetch after mid-instruction reset", int'(ir_wr), 1);

        // back-to-back: jump-and-link then load (R12)
        run_one('h03, 0, 1'b0);
        run_one('h23, 0, 1'b0);
        run_one('h05, 0, 1'b1);
        finish_run();
    end
endmodule